// File: doc/BRIEF.md
# Ethernet PHY Wrapper Power Sequencer

This block performs the bring-up and shutdown of two integrated Ethernet PHY wrapper instances in hardware, so that software does not have to step through the register writes itself. Each instance has two control registers. The first is a 9-bit general control word that holds the clock enables, the soft-reset releases, a serial-mode select and a drive-strength field. The second is a 5-bit serial-link control word that holds power, reset, PLL, signal-detect and power-state bits.

The host issues one command at a time on a valid-qualified bus. The command names an instance and an operation: initialise, shut down, store interface mode, power up or power down. The sequencer writes the register bits in order, waits out a fixed settling delay where the operation needs one, and in serial mode waits for a per-instance PLL-lock input. That input passes through a two-flop synchronizer and is watched for a bounded time. Every command ends with a one-cycle completion pulse, or with a one-cycle error pulse and an error code. A parameter sets the number of clock cycles per microsecond, and all timing is derived from it.

Top module: `eth_phy_seq`

## Requirements
- R1: After reset all four control words are zero, busy, done and err are low, err_code is 0, and the stored mode of each instance is "none".
- R2: A command accepted with cmd_inst greater than 1 ends with a single err pulse with err_code 1 on the cycle after acceptance, and changes no control word.
- R3: Initialise (cmd_op 0) clears both words of the instance on acceptance. After RST_WAIT_US microseconds of cycles it sets general bits 3:0 and loads drive strength 9 into bits 8:5, so the general word becomes 0x12F, and pulses done in the same cycle.
- R4: Shut down (cmd_op 1) clears both words of the instance on acceptance and pulses done RST_WAIT_US microseconds of cycles later.
- R5: Store mode (cmd_op 2) accepts only cmd_mode 1 (Ethernet) with cmd_sub 0 to 3 (RGMII variants) or cmd_sub 4 (SGMII). Any other combination gives err_code 2 and leaves the stored mode unchanged.
- R6: Power up (cmd_op 3) in SGMII mode sets general bit 4 and writes 0x07 to the serial word on acceptance. Once the synchronized PLL lock is seen, it ORs in bits 4:3 (serial word 0x1F) and pulses done.
- R7: If the synchronized PLL lock has not been seen within PLL_WAIT_US microseconds of cycles after acceptance, the command ends with err_code 3 and the control words are left as written.
- R8: Power up in RGMII or "none" mode clears general bit 4 and writes zero to the serial word, then pulses done on the next cycle.
- R9: Power down (cmd_op 4) clears general bit 4, keeps general bits 8:5 and 3:0, and writes zero to the serial word.
- R10: busy is high from acceptance through the response cycle, and commands presented while busy is high are ignored. done and err each last exactly one cycle and never occur together. Operation codes 5 to 7 give err_code 2.
- R11: The PLL lock input takes effect only after two synchronizer stages. An input that rises before clock edge n can change the serial word no earlier than edge n+2.
- R12: A command on one instance never alters the other instance's control words or stored mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; accepted when busy is low |
| cmd_inst | input | 2 | Instance index (0 or 1 valid) |
| cmd_op | input | 3 | 0 init, 1 exit, 2 store mode, 3 power up, 4 power down |
| cmd_mode | input | 2 | Mode for store mode; 1 = Ethernet |
| cmd_sub | input | 3 | Submode: 0..3 RGMII family, 4 SGMII |
| pll_ack_in | input | 2 | Asynchronous PLL lock per instance |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| err_code | output | 2 | 1 bad instance, 2 unsupported, 3 PLL timeout; 0 otherwise |
| gp0_q | output | 9 | General control word, instance 0 |
| gp1_q | output | 9 | General control word, instance 1 |
| sg0_q | output | 5 | Serial-link control word, instance 0 |
| sg1_q | output | 5 | Serial-link control word, instance 1 |

## Verification
The bench targets the off-by-one boundaries of the settle and lock windows. A design that miscounts there pulses done a cycle early or late, or reports a timeout while the lock is just arriving. A lock pulse is raised mid-poll and the serial word is sampled cycle by cycle, so a missing or extra synchronizer stage shows up as a word that changes one edge early or late. The bench also stores a rejected mode after a valid SGMII one and then powers up. A design that overwrote the stored mode would take the RGMII path and leave the serial word at zero. Commands sent while the block is busy must leave the other instance untouched, and a design that takes them in corrupts that instance's control word.

// File: rtl/eth_phy_seq.sv
module eth_phy_seq #(
  parameter int TICKS_PER_US = 250,
  parameter int RST_WAIT_US  = 5,
  parameter int PLL_WAIT_US  = 100,
  parameter int DRV_STRENGTH = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_inst,
  input  logic [2:0] cmd_op,
  input  logic [1:0] cmd_mode,
  input  logic [2:0] cmd_sub,
  input  logic [1:0] pll_ack_in,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [1:0] err_code,
  output logic [8:0] gp0_q,
  output logic [8:0] gp1_q,
  output logic [4:0] sg0_q,
  output logic [4:0] sg1_q
);
  localparam int WAIT_CYC = TICKS_PER_US * RST_WAIT_US;
  localparam int POLL_CYC = TICKS_PER_US * PLL_WAIT_US;
  localparam int LIM      = (POLL_CYC > WAIT_CYC) ? POLL_CYC : WAIT_CYC;
  localparam int CW       = $clog2(LIM + 1);
  localparam logic [3:0] DRV = DRV_STRENGTH[3:0];

  localparam logic [2:0] OP_INIT = 3'd0, OP_EXIT = 3'd1, OP_MODE = 3'd2,
                         OP_ON = 3'd3, OP_OFF = 3'd4;
  localparam logic [1:0] M_NONE = 2'd0, M_RGMII = 2'd1, M_SGMII = 2'd2;
  localparam logic [1:0] E_OK = 2'd0, E_INVAL = 2'd1, E_NOSUP = 2'd2, E_TMO = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_POLL, S_RESP} st_t;

  st_t         state;
  logic [CW-1:0] cnt;
  logic        sel;
  logic [2:0]  op_q;
  logic [1:0]  rsp;
  logic [1:0]  s1, s2;
  logic [8:0]  gp_q [2];
  logic [4:0]  sg_q [2];
  logic [1:0]  mode_q [2];
  logic        ci;

  assign ci = cmd_inst[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      sel   <= 1'b0;
      op_q  <= OP_INIT;
      rsp   <= E_OK;
      s1    <= '0;
      s2    <= '0;
      for (int k = 0; k < 2; k++) begin
        gp_q[k]   <= '0;
        sg_q[k]   <= '0;
        mode_q[k] <= M_NONE;
      end
    end else begin
      s1 <= pll_ack_in;
      s2 <= s1;
      case (state)
        S_IDLE: if (cmd_valid) begin
          sel   <= ci;
          op_q  <= cmd_op;
          cnt   <= '0;
          rsp   <= E_OK;
          state <= S_RESP;
          if (cmd_inst > 2'd1) rsp <= E_INVAL;
          else case (cmd_op)
            OP_INIT, OP_EXIT: begin
              gp_q[ci] <= '0;
              sg_q[ci] <= '0;
              state    <= S_WAIT;
            end
            OP_MODE:
              if (cmd_mode == 2'd1 && cmd_sub <= 3'd4)
                mode_q[ci] <= (cmd_sub == 3'd4) ? M_SGMII : M_RGMII;
              else
                rsp <= E_NOSUP;
            OP_ON:
              if (mode_q[ci] == M_SGMII) begin
                gp_q[ci][4] <= 1'b1;
                sg_q[ci]    <= 5'b00111;
                state       <= S_POLL;
              end else begin
                gp_q[ci][4] <= 1'b0;
                sg_q[ci]    <= '0;
              end
            OP_OFF: begin
              gp_q[ci][4] <= 1'b0;
              sg_q[ci]    <= '0;
            end
            default: rsp <= E_NOSUP;
          endcase
        end
        S_WAIT:
          if (cnt == CW'(WAIT_CYC - 1)) begin
            if (op_q == OP_INIT) gp_q[sel] <= gp_q[sel] | {DRV, 5'b01111};
            state <= S_RESP;
          end else cnt <= cnt + 1'b1;
        S_POLL:
          if (s2[sel]) begin
            sg_q[sel] <= sg_q[sel] | 5'b11000;
            state     <= S_RESP;
          end else if (cnt == CW'(POLL_CYC - 1)) begin
            rsp   <= E_TMO;
            state <= S_RESP;
          end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_RESP) && (rsp == E_OK);
  assign err      = (state == S_RESP) && (rsp != E_OK);
  assign err_code = err ? rsp : E_OK;
  assign gp0_q    = gp_q[0];
  assign gp1_q    = gp_q[1];
  assign sg0_q    = sg_q[0];
  assign sg1_q    = sg_q[1];

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n) (done || err) |=> !(done || err));
  assert_badinst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_inst > 2'd1) |=> (err && err_code == E_INVAL));
  assert_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && err_code == E_TMO) |-> $past(state) == S_POLL);
  assert_initval_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_INIT) |-> (sel ? gp1_q : gp0_q) == {DRV, 5'b01111});

  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sg_q[g][4]) |-> $past(s2[g]));
  end
endmodule

// File: tb/sim_eth_phy_seq.sv
module sim_eth_phy_seq;
  localparam int TPU = 4;
  localparam int WAITC = TPU * 5;
  localparam int POLLC = TPU * 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_inst = '0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_mode = '0;
  logic [2:0] cmd_sub = '0;
  logic [1:0] pll_ack_in = '0;
  logic busy, done, err;
  logic [1:0] err_code;
  logic [8:0] gp0_q, gp1_q;
  logic [4:0] sg0_q, sg1_q;

  int total = 0, bad = 0, cycles = 0;

  eth_phy_seq #(.TICKS_PER_US(TPU)) u0 (
    .clk, .rst_n, .cmd_valid, .cmd_inst, .cmd_op, .cmd_mode, .cmd_sub,
    .pll_ack_in, .busy, .done, .err, .err_code, .gp0_q, .gp1_q, .sg0_q, .sg1_q);

  always #2 clk = ~clk;

  // behavioural reference
  int m_ph = 0, m_cnt = 0, m_sel = 0, m_op = 0, m_rsp = 0;
  int m_gp [2] = '{0, 0};
  int m_sg [2] = '{0, 0};
  int m_md [2] = '{0, 0};
  bit [1:0] h1 = '0, h2 = '0;

  always @(posedge clk) begin
    bit [1:0] seen;
    seen = h2;
    h2 = h1;
    h1 = pll_ack_in;
    if (!rst_n) begin
      m_ph = 0; m_rsp = 0; h1 = '0; h2 = '0;
      for (int k = 0; k < 2; k++) begin m_gp[k] = 0; m_sg[k] = 0; m_md[k] = 0; end
    end else if (m_ph == 0) begin
      if (cmd_valid) begin
        int i;
        i = cmd_inst;
        m_sel = i; m_op = cmd_op; m_cnt = 0; m_rsp = 0; m_ph = 3;
        if (i > 1) m_rsp = 1;
        else if (cmd_op < 2) begin m_gp[i] = 0; m_sg[i] = 0; m_ph = 1; end
        else if (cmd_op == 2) begin
          if (cmd_mode == 1 && cmd_sub <= 4) m_md[i] = (cmd_sub == 4) ? 2 : 1;
          else m_rsp = 2;
        end else if (cmd_op == 3) begin
          if (m_md[i] == 2) begin m_gp[i] = m_gp[i] | 16; m_sg[i] = 7; m_ph = 2; end
          else begin m_gp[i] = m_gp[i] & ~16; m_sg[i] = 0; end
        end else if (cmd_op == 4) begin m_gp[i] = m_gp[i] & ~16; m_sg[i] = 0; end
        else m_rsp = 2;
      end
    end else if (m_ph == 1) begin
      m_cnt++;
      if (m_cnt == WAITC) begin
        if (m_op == 0) m_gp[m_sel] = m_gp[m_sel] | 'h12F;
        m_ph = 3;
      end
    end else if (m_ph == 2) begin
      m_cnt++;
      if (seen[m_sel]) begin m_sg[m_sel] = m_sg[m_sel] | 'h18; m_ph = 3; end
      else if (m_cnt == POLLC) begin m_rsp = 3; m_ph = 3; end
    end else m_ph = 0;
  end

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R10", "busy", busy, m_ph != 0);
    chk("R10", "done", done, m_ph == 3 && m_rsp == 0);
    chk("R10", "err", err, m_ph == 3 && m_rsp != 0);
    chk("R10", "err_code", err_code, (m_ph == 3) ? m_rsp : 0);
    chk("R12", "gp0", gp0_q, m_gp[0]);
    chk("R12", "gp1", gp1_q, m_gp[1]);
    chk("R12", "sg0", sg0_q, m_sg[0]);
    chk("R12", "sg1", sg1_q, m_sg[1]);
  end

  int r_code, r_lat;

  task automatic run(input int inst, input int op, input int md, input int sub);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_inst = 2'(inst); cmd_op = 3'(op);
    cmd_mode = 2'(md); cmd_sub = 3'(sub);
    r_lat = 0;
    do begin
      @(negedge clk);
      cmd_valid = 1'b0;
      r_lat++;
    end while (!(done || err));
    r_code = err ? int'(err_code) : 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset gp0", gp0_q, 0); chk("R1", "reset sg1", sg1_q, 0);
    chk("R1", "reset busy", busy, 0); chk("R1", "reset done/err", done | err, 0);
    rst_n = 1'b1;

    run(0, 0, 0, 0);
    chk("R3", "init code", r_code, 0); chk("R3", "init latency", r_lat, WAITC + 1);
    chk("R3", "init gp0", gp0_q, 'h12F); chk("R3", "init sg0", sg0_q, 0);

    run(1, 0, 0, 0);
    run(1, 3, 0, 0);
    chk("R8", "none power-up latency", r_lat, 1);
    chk("R8", "none gp1", gp1_q, 'h12F); chk("R8", "none sg1", sg1_q, 0);

    run(0, 2, 1, 4);
    chk("R5", "store sgmii", r_code, 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_inst = 2'd0; cmd_op = 3'd3;
    @(negedge clk); cmd_valid = 1'b0;
    chk("R6", "sgmii gp0", gp0_q, 'h13F); chk("R6", "sgmii sg0 pre", sg0_q, 7);
    repeat (5) @(negedge clk);
    pll_ack_in[0] = 1'b1;
    @(negedge clk); pll_ack_in[0] = 1'b0;
    chk("R11", "one stage", sg0_q, 7);
    @(negedge clk);
    chk("R11", "two stages", sg0_q, 7);
    @(negedge clk);
    chk("R11", "after sync", sg0_q, 'h1F); chk("R6", "done", done, 1);
    chk("R12", "gp1 untouched", gp1_q, 'h12F);

    run(0, 4, 0, 0);
    chk("R9", "off gp0", gp0_q, 'h12F); chk("R9", "off sg0", sg0_q, 0);

    run(1, 2, 1, 4);
    run(1, 3, 0, 0);
    chk("R7", "timeout code", r_code, 3); chk("R7", "timeout latency", r_lat, POLLC + 1);
    chk("R7", "timeout gp1", gp1_q, 'h13F); chk("R7", "timeout sg1", sg1_q, 7);

    run(1, 2, 1, 2);
    run(1, 3, 0, 0);
    chk("R8", "rgmii gp1", gp1_q, 'h12F); chk("R8", "rgmii sg1", sg1_q, 0);

    run(2, 0, 0, 0);
    chk("R2", "bad inst code", r_code, 1); chk("R2", "bad inst latency", r_lat, 1);
    chk("R2", "gp0 kept", gp0_q, 'h12F);

    run(0, 2, 0, 4);
    chk("R5", "bad mode", r_code, 2);
    run(0, 2, 1, 6);
    chk("R5", "bad submode", r_code, 2);
    pll_ack_in[0] = 1'b1;
    run(0, 3, 0, 0);
    chk("R5", "mode kept sgmii", sg0_q, 'h1F);
    pll_ack_in[0] = 1'b0;

    run(0, 5, 0, 0);
    chk("R10", "bad op", r_code, 2);

    run(0, 1, 0, 0);
    chk("R4", "exit code", r_code, 0); chk("R4", "exit latency", r_lat, WAITC + 1);
    chk("R4", "exit gp0", gp0_q, 0); chk("R4", "exit sg0", sg0_q, 0);

    @(negedge clk);
    cmd_valid = 1'b1; cmd_inst = 2'd1; cmd_op = 3'd0;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_inst = 2'd0; cmd_op = 3'd0;
    @(negedge clk); cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R10", "busy command ignored", gp0_q, 0);
    chk("R10", "idle after", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule